// File: doc/BRIEF.md
# Serial Memory Write-Permission and Status Unit

This unit holds the status byte of a small serial non-volatile memory with a 16K-byte address space and decides, write by write, whether a change is allowed. It receives command strobes that an opcode decoder upstream has already produced: latch enable, latch disable, status write (with its data byte), status read, memory byte write (with its target address) and end of command (chip select rising). It also receives the active-low hardware protect pin, which is brought into the clock domain through a two-flop synchroniser.

For every status write and every memory byte write, the unit returns a one-cycle grant pulse or a one-cycle deny pulse. The memory array and the shift logic use these pulses. The current status byte is always visible on a plain output. A status-read strobe returns a registered snapshot, marked by a one-cycle valid.

Every strobe interface has a valid signal only and no ready signal. The unit accepts a strobe in any cycle, so the upstream logic never sees back-pressure and never has to hold a strobe. The non-volatile fields (protect enable and the two block-protect bits) are modelled as registers. They reset to values set by parameters.

Top module: `nvm_wprot_ctrl`

## Requirements
- R1: The status byte has this layout: bit 7 is the protect enable, bits 3:2 are the block-protect code (bit 3 is the high bit), and bit 1 is the write latch. Bits 6:4 and bit 0 always read 0, whatever a status write carries.
- R2: During and after reset, the latch is 0, the protect enable and the block-protect code equal their parameter initial values, and all grant, deny and valid pulses are low.
- R3: The latch is set one cycle after a latch-enable strobe and cleared one cycle after a latch-disable strobe. The value a status write carries in bit 1 never reaches the latch.
- R4: A granted status write loads bit 7 and bits 3:2 from its data byte, clears the latch, and pulses the status grant one cycle after the strobe.
- R5: A status write made while the latch is 0 is denied. The deny pulse comes one cycle after the strobe, and no status bit changes.
- R6: When the protect enable is 1 and the synchronised pin is low, every status write is denied and the status is left unchanged. When the protect enable is 0, the pin has no effect.
- R7: The pin passes through two flip-flops. A status write strobed one cycle after the pin falls is still decided on the old, high pin level.
- R8: The block-protect code selects the protected addresses: 00 protects none, 01 protects 3000h-3FFFh, 10 protects 2000h-3FFFh, and 11 protects every address.
- R9: A memory byte write is granted only if the latch is 1 and the address is unprotected. Otherwise it is denied. Exactly one of the two pulses comes, one cycle after the strobe.
- R10: The end-of-command strobe clears the latch one cycle later, whether or not any bytes were blocked. Memory byte writes on their own leave the latch set.
- R11: A memory byte write never changes the status byte.
- R12: A status-read strobe raises the read valid for one cycle, one cycle later. The read data then equals the status byte as it stood at the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin_n | input | 1 | Hardware protect pin, active low, asynchronous |
| wel_set_stb | input | 1 | Latch-enable command strobe |
| wel_clr_stb | input | 1 | Latch-disable command strobe |
| sr_wr_stb | input | 1 | Status-write command strobe |
| sr_wr_data | input | 8 | Data byte of the status write |
| sr_rd_stb | input | 1 | Status-read command strobe |
| mem_wr_stb | input | 1 | Memory byte-write strobe |
| mem_wr_addr | input | ADDR_W | Target byte address |
| cmd_end_stb | input | 1 | End of command (chip select rising) |
| status_byte | output | 8 | Current status byte |
| sr_rd_valid | output | 1 | Read snapshot valid pulse |
| sr_rd_data | output | 8 | Read snapshot |
| sr_wr_grant | output | 1 | Status write accepted pulse |
| sr_wr_deny | output | 1 | Status write refused pulse |
| mem_wr_grant | output | 1 | Memory byte write allowed pulse |
| mem_wr_deny | output | 1 | Memory byte write refused pulse |

## Verification
Every result is registered once, so grant and deny pulses, read snapshots and status changes are all due one edge after the strobe. The bench drives strobes on the falling edge, holds them for one full cycle, and samples at the next falling edge, where exactly that edge's result is visible. The pin has two sync stages, so the bench waits three cycles after moving the pin before it relies on the new level. The only exception is the R7 case, which places a status write deliberately one cycle after the pin falls.

// File: rtl/nvm_wprot_pkg.sv
package nvm_wprot_pkg;
  typedef enum logic [1:0] {
    BLK_NONE    = 2'b00,
    BLK_QUARTER = 2'b01,
    BLK_HALF    = 2'b10,
    BLK_ALL     = 2'b11
  } blk_code_e;

  localparam int SR_PEN_BIT = 7;
  localparam int SR_BLK_HI  = 3;
  localparam int SR_BLK_LO  = 2;
  localparam int SR_WEL_BIT = 1;

  function automatic logic [7:0] pack_status(input logic pen, input logic [1:0] blk, input logic wel);
    pack_status = {pen, 3'b000, blk, wel, 1'b0};
  endfunction
endpackage

// File: rtl/nvm_wp_sync.sv
module nvm_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nvm_status_core.sv
module nvm_status_core
  import nvm_wprot_pkg::*;
#(
  parameter logic       INIT_PEN = 1'b0,
  parameter logic [1:0] INIT_BLK = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_hi,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       cmd_end,
  output logic       pen_q,
  output logic [1:0] blk_q,
  output logic       wel_q,
  output logic       grant_q,
  output logic       deny_q
);
  logic hw_lock;
  logic allow;
  logic take;

  assign hw_lock = pen_q && !pin_hi;
  assign allow   = wel_q && !hw_lock;
  assign take    = wr_stb && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q   <= INIT_PEN;
      blk_q   <= INIT_BLK;
      wel_q   <= 1'b0;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= take;
      deny_q  <= wr_stb && !allow;
      if (take) begin
        pen_q <= wr_data[SR_PEN_BIT];
        blk_q <= wr_data[SR_BLK_HI:SR_BLK_LO];
      end
      if (take || wel_clr || cmd_end) wel_q <= 1'b0;
      else if (wel_set)               wel_q <= 1'b1;
    end
  end
endmodule

// File: rtl/nvm_mem_gate.sv
module nvm_mem_gate
  import nvm_wprot_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wel,
  input  logic [1:0]        blk,
  output logic              grant_q,
  output logic              deny_q
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] top2;
  logic       locked;
  blk_code_e  code;

  assign top2 = wr_addr[TOP:TOP-1];
  assign code = blk_code_e'(blk);

  always_comb begin
    unique case (code)
      BLK_NONE:    locked = 1'b0;
      BLK_QUARTER: locked = (top2 == 2'b11);
      BLK_HALF:    locked = top2[1];
      default:     locked = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= wr_stb && wel && !locked;
      deny_q  <= wr_stb && !(wel && !locked);
    end
  end
endmodule

// File: rtl/nvm_wprot_ctrl.sv
module nvm_wprot_ctrl
  import nvm_wprot_pkg::*;
#(
  parameter int         ADDR_W      = 14,
  parameter int         SYNC_STAGES = 2,
  parameter logic       INIT_PEN    = 1'b0,
  parameter logic [1:0] INIT_BLK    = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin_n,
  input  logic              wel_set_stb,
  input  logic              wel_clr_stb,
  input  logic              sr_wr_stb,
  input  logic [7:0]        sr_wr_data,
  input  logic              sr_rd_stb,
  input  logic              mem_wr_stb,
  input  logic [ADDR_W-1:0] mem_wr_addr,
  input  logic              cmd_end_stb,
  output logic [7:0]        status_byte,
  output logic              sr_rd_valid,
  output logic [7:0]        sr_rd_data,
  output logic              sr_wr_grant,
  output logic              sr_wr_deny,
  output logic              mem_wr_grant,
  output logic              mem_wr_deny
);
  logic       pin_hi;
  logic       pen;
  logic [1:0] blk;
  logic       wel;

  nvm_wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wp_pin_n), .sync_out(pin_hi)
  );

  nvm_status_core #(.INIT_PEN(INIT_PEN), .INIT_BLK(INIT_BLK)) u_core (
    .clk(clk), .rst_n(rst_n), .pin_hi(pin_hi),
    .wel_set(wel_set_stb), .wel_clr(wel_clr_stb),
    .wr_stb(sr_wr_stb), .wr_data(sr_wr_data), .cmd_end(cmd_end_stb),
    .pen_q(pen), .blk_q(blk), .wel_q(wel),
    .grant_q(sr_wr_grant), .deny_q(sr_wr_deny)
  );

  nvm_mem_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_stb(mem_wr_stb), .wr_addr(mem_wr_addr),
    .wel(wel), .blk(blk), .grant_q(mem_wr_grant), .deny_q(mem_wr_deny)
  );

  assign status_byte = pack_status(pen, blk, wel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_rd_valid <= 1'b0;
      sr_rd_data  <= 8'h00;
    end else begin
      sr_rd_valid <= sr_rd_stb;
      if (sr_rd_stb) sr_rd_data <= status_byte;
    end
  end
endmodule

// File: rtl/nvm_wprot_ctrl_chk.sv
module nvm_wprot_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wel_set_stb,
  input logic       sr_rd_stb,
  input logic       mem_wr_stb,
  input logic [7:0] status_byte,
  input logic       sr_rd_valid,
  input logic       sr_wr_grant,
  input logic       sr_wr_deny,
  input logic       mem_wr_grant,
  input logic       mem_wr_deny
);
  a_r1_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[6:4] == 3'b000) && (status_byte[0] == 1'b0));

  a_r3_wel_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_byte[1]) |-> $past(wel_set_stb));

  a_r4_grant_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_grant |-> !status_byte[1]);

  a_r5_deny_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_deny |-> $stable(status_byte));

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_wr_stb) |-> $onehot({mem_wr_grant, mem_wr_deny}));

  a_r9_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_grant |-> $past(status_byte[1]));

  a_r12_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    sr_rd_valid |-> $past(sr_rd_stb));
endmodule

bind nvm_wprot_ctrl nvm_wprot_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wel_set_stb(wel_set_stb), .sr_rd_stb(sr_rd_stb),
  .mem_wr_stb(mem_wr_stb), .status_byte(status_byte), .sr_rd_valid(sr_rd_valid),
  .sr_wr_grant(sr_wr_grant), .sr_wr_deny(sr_wr_deny),
  .mem_wr_grant(mem_wr_grant), .mem_wr_deny(mem_wr_deny)
);

// File: tb/nvm_wprot_ctrl_tb_top.sv
module nvm_wprot_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_pin_n = 1'b1;
  logic wel_set_stb = 0, wel_clr_stb = 0, sr_wr_stb = 0, sr_rd_stb = 0;
  logic mem_wr_stb = 0, cmd_end_stb = 0;
  logic [7:0]  sr_wr_data = 8'h00;
  logic [13:0] mem_wr_addr = '0;
  logic [7:0]  status_byte, sr_rd_data;
  logic sr_rd_valid, sr_wr_grant, sr_wr_deny, mem_wr_grant, mem_wr_deny;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_wprot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wp_pin_n(wp_pin_n),
    .wel_set_stb(wel_set_stb), .wel_clr_stb(wel_clr_stb),
    .sr_wr_stb(sr_wr_stb), .sr_wr_data(sr_wr_data), .sr_rd_stb(sr_rd_stb),
    .mem_wr_stb(mem_wr_stb), .mem_wr_addr(mem_wr_addr), .cmd_end_stb(cmd_end_stb),
    .status_byte(status_byte), .sr_rd_valid(sr_rd_valid), .sr_rd_data(sr_rd_data),
    .sr_wr_grant(sr_wr_grant), .sr_wr_deny(sr_wr_deny),
    .mem_wr_grant(mem_wr_grant), .mem_wr_deny(mem_wr_deny)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_wren();
    wel_set_stb = 1; @(negedge clk); wel_set_stb = 0;
  endtask

  task automatic do_wrsr(input logic [7:0] d);
    sr_wr_stb = 1; sr_wr_data = d; @(negedge clk); sr_wr_stb = 0;
  endtask

  task automatic do_mwr(input logic [13:0] a);
    mem_wr_stb = 1; mem_wr_addr = a; @(negedge clk); mem_wr_stb = 0;
  endtask

  task automatic t_reset();
    chk("R2 status", status_byte, 8'h00);
    chk("R2 pulses", {sr_wr_grant, sr_wr_deny, mem_wr_grant, mem_wr_deny, sr_rd_valid}, 0);
  endtask

  task automatic t_latch();
    do_wren();            chk("R3 set", status_byte, 8'h02);
    wel_clr_stb = 1; @(negedge clk); wel_clr_stb = 0;
    chk("R3 clear", status_byte, 8'h00);
    do_wren();
    do_wrsr(8'hFF);
    chk("R4 grant", sr_wr_grant, 1);
    chk("R1 R3 R4 status", status_byte, 8'h8C);
  endtask

  task automatic t_deny_no_wel();
    do_wrsr(8'h00);
    chk("R5 deny", {sr_wr_grant, sr_wr_deny}, 2'b01);
    chk("R5 unchanged", status_byte, 8'h8C);
  endtask

  task automatic t_pin();
    do_wren();
    wp_pin_n = 0; idle(3);
    do_wrsr(8'h00);
    chk("R6 locked deny", {sr_wr_grant, sr_wr_deny}, 2'b01);
    chk("R6 unchanged", status_byte, 8'h8E);
    wp_pin_n = 1; idle(3);
    do_wrsr(8'h00);
    chk("R6 unlocked", status_byte, 8'h00);
    wp_pin_n = 0; idle(3);
    do_wren();
    do_wrsr(8'h04);
    chk("R6 pin ignored", {sr_wr_grant, status_byte}, 9'h104);
    wp_pin_n = 1; idle(3);
  endtask

  task automatic t_sync();
    do_wren(); do_wrsr(8'h80);
    do_wren();
    wp_pin_n = 0; @(negedge clk);
    do_wrsr(8'h80);
    chk("R7 old level used", {sr_wr_grant, status_byte}, 9'h180);
    do_wren(); idle(2);
    do_wrsr(8'h00);
    chk("R7 new level", {sr_wr_deny, status_byte}, 9'h182);
    wp_pin_n = 1; idle(3);
    do_wrsr(8'h00);
    chk("R7 restore", status_byte, 8'h00);
  endtask

  task automatic t_mem();
    logic [13:0] addrs [6] = '{14'h0000, 14'h1FFF, 14'h2000, 14'h2FFF, 14'h3000, 14'h3FFF};
    for (int b = 0; b < 4; b++) begin
      do_wren(); do_wrsr(8'(b << 2));
      do_wren();
      for (int k = 0; k < 6; k++) begin
        logic prot;
        case (b)
          0: prot = 0;
          1: prot = (addrs[k] >= 14'h3000);
          2: prot = (addrs[k] >= 14'h2000);
          default: prot = 1;
        endcase
        do_mwr(addrs[k]);
        chk("R8 R9 gate", {mem_wr_grant, mem_wr_deny}, prot ? 2'b01 : 2'b10);
        chk("R10 R11 status kept", status_byte, 8'(b << 2) | 8'h02);
      end
      cmd_end_stb = 1; @(negedge clk); cmd_end_stb = 0;
      chk("R10 end clears", status_byte, 8'(b << 2));
    end
    do_wren(); do_wrsr(8'h00);
    do_mwr(14'h0000);
    chk("R9 no latch deny", {mem_wr_grant, mem_wr_deny}, 2'b01);
  endtask

  task automatic t_read();
    do_wren();
    sr_rd_stb = 1; @(negedge clk); sr_rd_stb = 0;
    chk("R12 valid", sr_rd_valid, 1);
    chk("R12 data", sr_rd_data, 8'h02);
    @(negedge clk);
    chk("R12 one cycle", sr_rd_valid, 0);
  endtask

  initial begin
    idle(2);
    t_reset();
    rst_n = 1;
    idle(3);
    t_latch();
    t_deny_no_wel();
    t_pin();
    t_sync();
    t_mem();
    t_read();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule